// File: doc/BRIEF.md
# Data Cache with Line-Level Hint Commands

A small direct-mapped write-back data cache. It serves ordinary word loads and stores, and five line-level commands: flush-keep (write a dirty line back and keep it), touch, touch-for-store, allocate-without-fetch and zero-line. Each command names its line by an effective byte address. The cache keeps a tag, a valid bit and a dirty bit for each line. It runs victim write-backs and line fills over a line-wide memory port that has separate read and write request channels.

The CPU side is a valid/ready command channel with one-cycle completion. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. The requester may hold `cmd_valid` for as long as it likes while `cmd_ready` is low. `cmd_ready` stays low from acceptance until the cycle after `cmd_done` pulses, so only one command is in flight. The memory side is back-pressured by acknowledges. A request stays asserted, with a constant address and line, until the cycle in which its acknowledge is high. Read data is taken in that same cycle. Geometry defaults to 16 lines of four 32-bit words.

Top module: `dcb_cache_top`

## Requirements
- R1: A load returns the addressed word on `cmd_rdata`, valid from the cycle `cmd_done` is high. A store overwrites one word and marks the line dirty. A load or store miss first fills the whole line from memory, with exactly one read request.
- R2: When a fill or install of a different tag lands on a valid dirty line, that victim is written to memory first, at its own line address, with exactly one write request.
- R3: Flush-keep on a dirty hit writes the full line once. The line then stays valid and clean: later loads hit without a read, and a second flush-keep makes no traffic.
- R4: Flush-keep on a miss, or on a clean hit, completes with no memory request.
- R5: Touch and touch-for-store on a cacheable miss fill the line with one read, so that a later load hits. On a hit, or with `cmd_cacheable` low, they complete with no memory request and no change of state. The flag is consulted only by these two commands.
- R6: Allocate on a miss installs the line without any read and marks it dirty. The slot's existing data bits are kept. Allocate on a hit changes nothing.
- R7: Zero-line installs the line without any read, clears every word to 0 and marks it dirty, on a hit as well as on a miss.
- R8: None of the line-level commands (flush-keep, touch, touch-for-store, allocate, zero-line) or the no-op alters `cmd_rdata`.
- R9: `cmd_ready` is high only while idle. It drops in the cycle after acceptance. `cmd_done` is a one-cycle pulse, and `cmd_ready` returns high in the next cycle.
- R10: A memory request holds, with a stable address, until it is acknowledged. Read and write requests are never high together. Allocate, zero-line and flush-keep never issue a read.
- R11: Opcodes are 0 load, 1 store, 2 flush-keep, 3 touch, 4 touch-for-store, 5 allocate, 6 zero-line, 7 no-op. The no-op completes with no effect. Address bits [3:2] select the word, bits [7:4] the line and bits [31:8] form the tag. Bits [1:0] are ignored. The memory line address is address bits [31:4].
- R12: After reset, every line is invalid and its data is zero, `cmd_ready` is high, and `cmd_done` and both memory requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Cache idle, command can be taken |
| cmd_op | input | 3 | Opcode (see R11) |
| cmd_addr | input | 32 | Effective byte address |
| cmd_wdata | input | 32 | Store data |
| cmd_cacheable | input | 1 | Address is cacheable (touch commands only) |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_rdata | output | 32 | Word returned by the last load |
| mem_rd_req | output | 1 | Line read request |
| mem_rd_addr | output | 28 | Line address to read |
| mem_rd_ack | input | 1 | Read acknowledge; line data valid |
| mem_rd_line | input | 128 | Line read from memory, word 0 in bits [31:0] |
| mem_wr_req | output | 1 | Line write request |
| mem_wr_addr | output | 28 | Line address to write |
| mem_wr_line | output | 128 | Line written, word 0 in bits [31:0] |
| mem_wr_ack | input | 1 | Write acknowledge |

## Verification
The bench aims at slot conflicts between four tags sharing 16 indices. Those conflicts exercise dirty-victim eviction ahead of fills, allocates and zeroes; a design that skipped the write-back would lose stores, and a final flush-and-compare of memory exposes that. Flush-keep is checked to leave the line valid and clean. A design that invalidated the line would show an extra read on the next load, and one that left it dirty would write a second time. Allocate and zero-line are checked for zero reads and for a dirty mark. Hints are checked for leaving the load data alone. Touch with the non-cacheable flag must produce no traffic.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  typedef enum logic [2:0] {
    OP_LOAD    = 3'd0,
    OP_STORE   = 3'd1,
    OP_FLUSH   = 3'd2,
    OP_TOUCH   = 3'd3,
    OP_TOUCHST = 3'd4,
    OP_ALLOC   = 3'd5,
    OP_ZERO    = 3'd6,
    OP_NOP     = 3'd7
  } dcb_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_WBACK,
    ST_FILL,
    ST_DONE
  } dcb_state_e;
endpackage

// File: rtl/dcb_tag_store.sv
module dcb_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 24,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  output logic             rd_dirty,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_valid,
  input  logic             wr_dirty
);
  logic [TAG_W-1:0] tag_q   [LINES];
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else if (wr_en) begin
      tag_q[idx]   <= wr_tag;
      valid_q[idx] <= wr_valid;
      dirty_q[idx] <= wr_dirty;
    end
  end

  assign rd_tag   = tag_q[idx];
  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];

  // R12
  dirty_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_q & ~valid_q) == '0);
endmodule

// File: rtl/dcb_line_store.sv
module dcb_line_store #(
  parameter int LINES  = 16,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line
);
  logic [LINE_W-1:0] data_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) data_q[i] <= '0;
    end else if (wr_en) begin
      data_q[idx] <= wr_line;
    end
  end

  assign rd_line = data_q[idx];
endmodule

// File: rtl/dcb_line_merge.sv
module dcb_line_merge #(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int LINE_W = WORD_W * LINE_WORDS
) (
  input  logic [LINE_W-1:0] cache_line,
  input  logic [LINE_W-1:0] mem_line,
  input  logic              use_mem,
  input  logic [WSEL_W-1:0] wsel,
  input  logic [WORD_W-1:0] word,
  input  logic              put_word,
  input  logic              zero_all,
  output logic [LINE_W-1:0] out_line
);
  logic [LINE_W-1:0] base;
  assign base = use_mem ? mem_line : cache_line;

  for (genvar g = 0; g < LINE_WORDS; g++) begin : g_word
    always_comb begin
      if (zero_all)
        out_line[g*WORD_W +: WORD_W] = '0;
      else if (put_word && wsel == WSEL_W'(g))
        out_line[g*WORD_W +: WORD_W] = word;
      else
        out_line[g*WORD_W +: WORD_W] = base[g*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/dcb_ctrl.sv
module dcb_ctrl
  import dcb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 16,
  localparam int BYTE_OFS = $clog2(WORD_W / 8),
  localparam int WSEL_W   = $clog2(LINE_WORDS),
  localparam int IDX_W    = $clog2(LINES),
  localparam int TAG_W    = ADDR_W - IDX_W - WSEL_W - BYTE_OFS,
  localparam int LINE_W   = WORD_W * LINE_WORDS,
  localparam int LADDR_W  = TAG_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [2:0]         cmd_op,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [WORD_W-1:0]  cmd_wdata,
  input  logic               cmd_cacheable,
  output logic               cmd_done,
  output logic [WORD_W-1:0]  cmd_rdata,
  output logic               mem_rd_req,
  output logic [LADDR_W-1:0] mem_rd_addr,
  input  logic               mem_rd_ack,
  input  logic [LINE_W-1:0]  mem_rd_line,
  output logic               mem_wr_req,
  output logic [LADDR_W-1:0] mem_wr_addr,
  output logic [LINE_W-1:0]  mem_wr_line,
  input  logic               mem_wr_ack,
  output logic [IDX_W-1:0]   look_idx,
  input  logic [TAG_W-1:0]   cur_tag,
  input  logic               cur_valid,
  input  logic               cur_dirty,
  input  logic [LINE_W-1:0]  cur_line,
  output logic               tag_we,
  output logic [TAG_W-1:0]   tag_wr_tag,
  output logic               tag_wr_valid,
  output logic               tag_wr_dirty,
  output logic               line_we,
  output logic               mg_use_mem,
  output logic [WSEL_W-1:0]  mg_wsel,
  output logic [WORD_W-1:0]  mg_word,
  output logic               mg_put_word,
  output logic               mg_zero
);
  dcb_state_e        st_q, st_d;
  dcb_op_e           op_q;
  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WSEL_W-1:0] wsel_q;
  logic [WORD_W-1:0] wdata_q;
  logic              cach_q;
  logic [WORD_W-1:0] rdata_q;
  logic              take_cache_word, take_mem_word;
  logic              hit, victim_dirty;
  logic [BYTE_OFS-1:0] unused_byte_ofs;

  assign unused_byte_ofs = cmd_addr[BYTE_OFS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_NOP;
      tag_q   <= '0;
      idx_q   <= '0;
      wsel_q  <= '0;
      wdata_q <= '0;
      cach_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && cmd_valid) begin
        op_q    <= dcb_op_e'(cmd_op);
        tag_q   <= cmd_addr[ADDR_W-1 -: TAG_W];
        idx_q   <= cmd_addr[BYTE_OFS+WSEL_W +: IDX_W];
        wsel_q  <= cmd_addr[BYTE_OFS +: WSEL_W];
        wdata_q <= cmd_wdata;
        cach_q  <= cmd_cacheable;
      end
      if (take_cache_word)
        rdata_q <= cur_line[wsel_q*WORD_W +: WORD_W];
      else if (take_mem_word)
        rdata_q <= mem_rd_line[wsel_q*WORD_W +: WORD_W];
    end
  end

  assign hit          = cur_valid && (cur_tag == tag_q);
  assign victim_dirty = cur_valid && cur_dirty && !hit;

  always_comb begin
    st_d            = st_q;
    tag_we          = 1'b0;
    tag_wr_valid    = 1'b1;
    tag_wr_dirty    = 1'b0;
    line_we         = 1'b0;
    mg_use_mem      = 1'b0;
    mg_put_word     = 1'b0;
    mg_zero         = 1'b0;
    take_cache_word = 1'b0;
    take_mem_word   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (cmd_valid) st_d = ST_DECIDE;
      ST_DECIDE: begin
        unique case (op_q)
          OP_LOAD, OP_STORE: begin
            if (hit) begin
              if (op_q == OP_LOAD) begin
                take_cache_word = 1'b1;
              end else begin
                line_we      = 1'b1;
                mg_put_word  = 1'b1;
                tag_we       = 1'b1;
                tag_wr_dirty = 1'b1;
              end
              st_d = ST_DONE;
            end else begin
              st_d = victim_dirty ? ST_WBACK : ST_FILL;
            end
          end
          OP_FLUSH: st_d = (hit && cur_dirty) ? ST_WBACK : ST_DONE;
          OP_TOUCH, OP_TOUCHST: begin
            if (cach_q && !hit) st_d = victim_dirty ? ST_WBACK : ST_FILL;
            else                st_d = ST_DONE;
          end
          OP_ALLOC: begin
            if (hit) begin
              st_d = ST_DONE;
            end else if (victim_dirty) begin
              st_d = ST_WBACK;
            end else begin
              tag_we       = 1'b1;
              tag_wr_dirty = 1'b1;
              st_d         = ST_DONE;
            end
          end
          OP_ZERO: begin
            if (victim_dirty) begin
              st_d = ST_WBACK;
            end else begin
              line_we      = 1'b1;
              mg_zero      = 1'b1;
              tag_we       = 1'b1;
              tag_wr_dirty = 1'b1;
              st_d         = ST_DONE;
            end
          end
          default: st_d = ST_DONE;
        endcase
      end
      ST_WBACK: begin
        if (mem_wr_ack) begin
          unique case (op_q)
            OP_FLUSH: begin
              tag_we = 1'b1;
              st_d   = ST_DONE;
            end
            OP_ALLOC: begin
              tag_we       = 1'b1;
              tag_wr_dirty = 1'b1;
              st_d         = ST_DONE;
            end
            OP_ZERO: begin
              line_we      = 1'b1;
              mg_zero      = 1'b1;
              tag_we       = 1'b1;
              tag_wr_dirty = 1'b1;
              st_d         = ST_DONE;
            end
            default: st_d = ST_FILL;
          endcase
        end
      end
      ST_FILL: begin
        if (mem_rd_ack) begin
          line_we       = 1'b1;
          mg_use_mem    = 1'b1;
          mg_put_word   = (op_q == OP_STORE);
          tag_we        = 1'b1;
          tag_wr_dirty  = (op_q == OP_STORE);
          take_mem_word = (op_q == OP_LOAD);
          st_d          = ST_DONE;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign look_idx    = idx_q;
  assign tag_wr_tag  = tag_q;
  assign mg_wsel     = wsel_q;
  assign mg_word     = wdata_q;
  assign cmd_ready   = (st_q == ST_IDLE);
  assign cmd_done    = (st_q == ST_DONE);
  assign cmd_rdata   = rdata_q;
  assign mem_rd_req  = (st_q == ST_FILL);
  assign mem_rd_addr = {tag_q, idx_q};
  assign mem_wr_req  = (st_q == ST_WBACK);
  assign mem_wr_addr = {cur_tag, idx_q};
  assign mem_wr_line = cur_line;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);
  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  // R9
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> cmd_ready);
  // R10
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req));
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));
  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_line)));
  // R10 R6 R7 R3
  no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && (op_q == OP_ALLOC || op_q == OP_ZERO || op_q == OP_FLUSH)) |-> !mem_rd_req);
  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && op_q != OP_LOAD) |-> $stable(cmd_rdata));
endmodule

// File: rtl/dcb_cache_top.sv
module dcb_cache_top #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 16,
  localparam int BYTE_OFS = $clog2(WORD_W / 8),
  localparam int WSEL_W   = $clog2(LINE_WORDS),
  localparam int IDX_W    = $clog2(LINES),
  localparam int TAG_W    = ADDR_W - IDX_W - WSEL_W - BYTE_OFS,
  localparam int LINE_W   = WORD_W * LINE_WORDS,
  localparam int LADDR_W  = TAG_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [2:0]         cmd_op,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [WORD_W-1:0]  cmd_wdata,
  input  logic               cmd_cacheable,
  output logic               cmd_done,
  output logic [WORD_W-1:0]  cmd_rdata,
  output logic               mem_rd_req,
  output logic [LADDR_W-1:0] mem_rd_addr,
  input  logic               mem_rd_ack,
  input  logic [LINE_W-1:0]  mem_rd_line,
  output logic               mem_wr_req,
  output logic [LADDR_W-1:0] mem_wr_addr,
  output logic [LINE_W-1:0]  mem_wr_line,
  input  logic               mem_wr_ack
);
  logic [IDX_W-1:0]  look_idx;
  logic [TAG_W-1:0]  cur_tag, tag_wr_tag;
  logic              cur_valid, cur_dirty;
  logic [LINE_W-1:0] cur_line, new_line;
  logic              tag_we, tag_wr_valid, tag_wr_dirty, line_we;
  logic              mg_use_mem, mg_put_word, mg_zero;
  logic [WSEL_W-1:0] mg_wsel;
  logic [WORD_W-1:0] mg_word;

  dcb_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .LINES(LINES)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_cacheable(cmd_cacheable),
    .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
    .mem_rd_line(mem_rd_line),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_line(mem_wr_line),
    .mem_wr_ack(mem_wr_ack),
    .look_idx(look_idx), .cur_tag(cur_tag), .cur_valid(cur_valid),
    .cur_dirty(cur_dirty), .cur_line(cur_line),
    .tag_we(tag_we), .tag_wr_tag(tag_wr_tag), .tag_wr_valid(tag_wr_valid),
    .tag_wr_dirty(tag_wr_dirty), .line_we(line_we),
    .mg_use_mem(mg_use_mem), .mg_wsel(mg_wsel), .mg_word(mg_word),
    .mg_put_word(mg_put_word), .mg_zero(mg_zero)
  );

  dcb_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst_n(rst_n), .idx(look_idx),
    .rd_tag(cur_tag), .rd_valid(cur_valid), .rd_dirty(cur_dirty),
    .wr_en(tag_we), .wr_tag(tag_wr_tag), .wr_valid(tag_wr_valid),
    .wr_dirty(tag_wr_dirty)
  );

  dcb_line_store #(.LINES(LINES), .LINE_W(LINE_W)) lines_i (
    .clk(clk), .rst_n(rst_n), .idx(look_idx),
    .rd_line(cur_line), .wr_en(line_we), .wr_line(new_line)
  );

  dcb_line_merge #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) merge_i (
    .cache_line(cur_line), .mem_line(mem_rd_line), .use_mem(mg_use_mem),
    .wsel(mg_wsel), .word(mg_word), .put_word(mg_put_word),
    .zero_all(mg_zero), .out_line(new_line)
  );
endmodule

// File: tb/dcb_cache_top_tb_top.sv
`timescale 1ns/1ps
module dcb_cache_top_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [2:0]   cmd_op = 3'd7;
  logic [31:0]  cmd_addr = '0;
  logic [31:0]  cmd_wdata = '0;
  logic         cmd_cacheable = 1'b1;
  logic         cmd_done;
  logic [31:0]  cmd_rdata;
  logic         mem_rd_req;
  logic [27:0]  mem_rd_addr;
  logic         mem_rd_ack = 1'b0;
  logic [127:0] mem_rd_line = '0;
  logic         mem_wr_req;
  logic [27:0]  mem_wr_addr;
  logic [127:0] mem_wr_line;
  logic         mem_wr_ack = 1'b0;

  always #2.5 clk = ~clk;

  dcb_cache_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_cacheable(cmd_cacheable),
    .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
    .mem_rd_line(mem_rd_line),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_line(mem_wr_line),
    .mem_wr_ack(mem_wr_ack)
  );

  int n_chk = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0;
  bit finished = 0;

  logic [31:0] mem     [64][4];
  logic [31:0] ref_mem [64][4];
  logic [31:0] m_line  [16][4];
  int          m_tag   [16];
  bit          m_val   [16];
  bit          m_dirty [16];
  logic [31:0] exp_rdata = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] init_word(input int la, input int w);
    return 32'h5A00_0000 | (la << 8) | w;
  endfunction

  task automatic evict(input int i, inout int ewr);
    if (m_val[i] && m_dirty[i]) begin
      for (int w = 0; w < 4; w++) ref_mem[m_tag[i]*16 + i][w] = m_line[i][w];
      ewr++;
    end
  endtask

  task automatic fill(input int i, input int t);
    for (int w = 0; w < 4; w++) m_line[i][w] = ref_mem[t*16 + i][w];
    m_tag[i] = t; m_val[i] = 1; m_dirty[i] = 0;
  endtask

  // reference model from the requirements
  task automatic model_step(input logic [2:0] op, input logic [31:0] a, input logic [31:0] wd,
                            input bit c, output int erd, output int ewr);
    int i = int'(a[7:4]);
    int t = int'(a[31:8]);
    int w = int'(a[3:2]);
    bit hit = m_val[i] && (m_tag[i] == t);
    erd = 0; ewr = 0;
    case (op)
      3'd0, 3'd1: begin
        if (!hit) begin evict(i, ewr); fill(i, t); erd = 1; end
        if (op == 3'd0) exp_rdata = m_line[i][w];
        else begin m_line[i][w] = wd; m_dirty[i] = 1; end
      end
      3'd2: if (hit && m_dirty[i]) begin evict(i, ewr); m_dirty[i] = 0; end
      3'd3, 3'd4: if (c && !hit) begin evict(i, ewr); fill(i, t); erd = 1; end
      3'd5: if (!hit) begin evict(i, ewr); m_tag[i] = t; m_val[i] = 1; m_dirty[i] = 1; end
      3'd6: begin
        if (!hit) begin evict(i, ewr); m_tag[i] = t; m_val[i] = 1; end
        for (int k = 0; k < 4; k++) m_line[i][k] = '0;
        m_dirty[i] = 1;
      end
      default: ;
    endcase
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [31:0] a, input logic [31:0] wd,
                        input bit c, input string req);
    int erd, ewr;
    model_step(op, a, wd, c, erd, ewr);
    @(negedge clk);
    chk(cmd_ready, "R9 idle ready", {31'd0, cmd_ready}, 32'd1);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_wdata = wd; cmd_cacheable = c;
    rd_cnt = 0; wr_cnt = 0;
    @(negedge clk);
    cmd_valid = 0;
    chk(!cmd_ready, "R9 busy", {31'd0, cmd_ready}, 32'd0);
    while (!cmd_done) @(negedge clk);
    chk(cmd_rdata == exp_rdata, (op == 3'd0) ? req : "R8 rdata", cmd_rdata, exp_rdata);
    chk(rd_cnt == erd, {req, " reads"}, rd_cnt, erd);
    chk(wr_cnt == ewr, {req, " writes"}, wr_cnt, ewr);
    @(negedge clk);
    chk(!cmd_done && cmd_ready, "R9 done pulse", {30'd0, cmd_done, cmd_ready}, 32'd1);
  endtask

  // memory responder with random acknowledge delay
  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      mem_rd_ack = 0; mem_wr_ack = 0;
      if (mem_rd_req || mem_wr_req) begin
        if (dly > 0) dly--;
        else if (mem_rd_req) begin
          chk(mem_rd_addr[27:6] == '0, "R11 read addr", {4'd0, mem_rd_addr}, 32'd0);
          for (int w = 0; w < 4; w++) mem_rd_line[w*32 +: 32] = mem[mem_rd_addr[5:0]][w];
          mem_rd_ack = 1; rd_cnt++; dly = $urandom % 3;
        end else begin
          chk(mem_wr_addr[27:6] == '0, "R2 write addr", {4'd0, mem_wr_addr}, 32'd0);
          for (int w = 0; w < 4; w++) mem[mem_wr_addr[5:0]][w] = mem_wr_line[w*32 +: 32];
          mem_wr_ack = 1; wr_cnt++; dly = $urandom % 3;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int l = 0; l < 64; l++)
      for (int w = 0; w < 4; w++) begin mem[l][w] = init_word(l, w); ref_mem[l][w] = init_word(l, w); end
    for (int i = 0; i < 16; i++) begin
      m_tag[i] = 0; m_val[i] = 0; m_dirty[i] = 0;
      for (int w = 0; w < 4; w++) m_line[i][w] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready && !cmd_done && !mem_rd_req && !mem_wr_req, "R12 reset outputs",
        {28'd0, cmd_ready, cmd_done, mem_rd_req, mem_wr_req}, 32'h8);
    chk(cmd_rdata == '0, "R12 reset rdata", cmd_rdata, 32'd0);

    do_cmd(3'd0, 32'h000, 0, 1, "R1 load miss");
    do_cmd(3'd1, 32'h004, 32'hDEAD_BEEF, 1, "R1 store hit");
    do_cmd(3'd0, 32'h004, 0, 1, "R1 load after store");
    do_cmd(3'd2, 32'h007, 0, 1, "R3 flush dirty");
    chk(mem[0][1] == 32'hDEAD_BEEF, "R3 line in memory", mem[0][1], 32'hDEAD_BEEF);
    do_cmd(3'd0, 32'h004, 0, 1, "R3 still valid");
    do_cmd(3'd2, 32'h000, 0, 1, "R3 R4 flush clean");
    do_cmd(3'd2, 32'h100, 0, 1, "R4 flush miss");
    do_cmd(3'd3, 32'h110, 0, 0, "R5 touch noncacheable");
    do_cmd(3'd3, 32'h110, 0, 1, "R5 touch miss");
    do_cmd(3'd0, 32'h118, 0, 1, "R5 load after touch");
    do_cmd(3'd4, 32'h210, 0, 1, "R5 touchst replace");
    do_cmd(3'd4, 32'h214, 0, 1, "R5 touchst hit");
    do_cmd(3'd1, 32'h020, 32'h1234_5678, 1, "R1 store miss");
    do_cmd(3'd6, 32'h121, 0, 1, "R2 R7 zero dirty victim");
    do_cmd(3'd0, 32'h12C, 0, 1, "R7 zero line reads 0");
    do_cmd(3'd5, 32'h230, 0, 1, "R6 alloc fresh");
    do_cmd(3'd0, 32'h234, 0, 1, "R6 R12 alloc keeps zero data");
    do_cmd(3'd5, 32'h330, 0, 1, "R2 R6 alloc dirty victim");
    do_cmd(3'd5, 32'h330, 0, 1, "R6 alloc hit");
    do_cmd(3'd0, 32'h004, 0, 1, "R1 reload");
    do_cmd(3'd3, 32'h340, 0, 1, "R8 touch keeps rdata");
    do_cmd(3'd7, 32'h004, 32'hFFFF_FFFF, 1, "R11 no-op");
    do_cmd(3'd0, 32'h004, 0, 1, "R11 no-op left line");

    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      a = (($urandom % 4) << 8) | (($urandom % 16) << 4) | ($urandom % 16);
      do_cmd(3'($urandom % 8), a, $urandom, ($urandom % 4) != 0, "R1 R2 random");
    end

    for (int i = 0; i < 16; i++)
      if (m_val[i]) do_cmd(3'd2, (m_tag[i] << 8) | (i << 4), 0, 1, "R3 final flush");
    for (int l = 0; l < 64; l++)
      for (int w = 0; w < 4; w++)
        chk(mem[l][w] == ref_mem[l][w], "R2 R3 memory image", mem[l][w], ref_mem[l][w]);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule